// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

When a host CPU runs an interrupt-acknowledge cycle, this block answers it. At the first clock edge that sees the acknowledge request, it captures the current arbitration winner (channel number and interrupt type) together with the vector format code. For the rest of the cycle it drives an 8-bit vector onto the data bus. The vector is made from a programmable base register, with the captured channel and type merged into its low bits as the format code selects.

It also ends the cycle with a data-acknowledge signal. That signal rises a fixed number of clocks after the cycle starts and falls when the host withdraws its request. One format drives no vector at all. In that format the bus stays released, but the acknowledge is still given. The captured channel and type are also brought out, so that the global register view shows the same winner as the vector.

Top module: `iack_vector_gen`

## Requirements
- R1: After reset, `bus_oe`, `dack`, `bus_dout`, `ctx_chan` and `ctx_type` are all zero.
- R2: Format code 2'b00 drives all 8 bits of `ivec_base` unchanged on `bus_dout`.
- R3: Format code 2'b01 drives `{ivec_base[7:2], channel[1:0]}` on `bus_dout`.
- R4: Format code 2'b10 drives `{ivec_base[7:5], channel[1:0], type[2:0]}` on `bus_dout`.
- R5: Format code 2'b11 keeps `bus_oe` low and `bus_dout` at zero for the whole acknowledge cycle.
- R6: `bus_oe` rises the cycle after the first clock edge that samples `iack_req` high, in every format except 2'b11. It falls the cycle after the first edge that samples `iack_req` low.
- R7: `dack` rises `DACK_DELAY` (default 2) clock edges after the starting edge, in every format including 2'b11. It stays high while `iack_req` is held, and falls the cycle after `iack_req` is sampled low.
- R8: Channel and type are captured at the starting edge. They appear on `ctx_chan` and `ctx_type` and hold until the next acknowledge cycle starts. Changes on `win_chan` or `win_type` during a cycle have no effect on the vector.
- R9: The format code is captured at the starting edge. A change on `ivec_mode` during a cycle has no effect on `bus_dout` or `bus_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iack_req | input | 1 | Host acknowledge cycle in progress (synchronous, active high) |
| ivec_base | input | 8 | Programmable vector base register |
| ivec_mode | input | 2 | Vector format code |
| win_chan | input | 2 | Current arbitration winner channel |
| win_type | input | 3 | Current arbitration winner interrupt type |
| bus_dout | output | 8 | Vector data; zero when not driven |
| bus_oe | output | 1 | Data bus output enable |
| dack | output | 1 | Data acknowledge to host |
| ctx_chan | output | 2 | Captured channel for the global register view |
| ctx_type | output | 3 | Captured type for the global register view |

## Verification
The assertions assume three things about the inputs. First, `iack_req` is a clean synchronous level that never goes high during reset. Second, `ivec_base` is treated as a configuration register and stays stable while an acknowledge cycle is open. Third, each cycle lasts at least `DACK_DELAY` clocks, so that a bus-stability property holds across the cycle. The stimulus changes `ivec_base` only while `iack_req` is low, and it holds every request for four or more clocks. Winner and format inputs, by contrast, are deliberately changed mid-cycle to show that the captured values win.

// File: rtl/iack_pkg.sv
package iack_pkg;

  typedef enum logic [1:0] {
    VF_FULL      = 2'b00,
    VF_CHAN      = 2'b01,
    VF_CHAN_TYPE = 2'b10,
    VF_NONE      = 2'b11
  } vfmt_e;

endpackage

// File: rtl/iack_cycle_ctl.sv
module iack_cycle_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic iack_req,
  output logic start,
  output logic active
);

  logic active_q;
  logic active_d;

  // next state: the cycle is open while the request is sampled high
  always_comb begin
    active_d = iack_req;
    start    = iack_req && !active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  assign active = active_q;

  AST_ACTIVE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req |=> active); // R6

endmodule

// File: rtl/iack_ctx_latch.sv
module iack_ctx_latch
  import iack_pkg::*;
#(
  parameter int CHAN_W = 2,
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic [TYPE_W-1:0] type_in,
  input  vfmt_e             mode_in,
  output logic [CHAN_W-1:0] chan_q,
  output logic [TYPE_W-1:0] type_q,
  output vfmt_e             mode_q
);

  logic [CHAN_W-1:0] chan_d;
  logic [TYPE_W-1:0] type_d;
  vfmt_e             mode_d;

  always_comb begin
    chan_d = chan_q;
    type_d = type_q;
    mode_d = mode_q;
    if (start) begin
      chan_d = chan_in;
      type_d = type_in;
      mode_d = mode_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      type_q <= '0;
      mode_q <= VF_FULL;
    end else if (start) begin
      chan_q <= chan_d;
      type_q <= type_d;
      mode_q <= mode_d;
    end
  end

  AST_CTX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> ($stable(chan_q) && $stable(type_q))); // R8
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start) |=> $stable(mode_q)); // R9

endmodule

// File: rtl/iack_vec_fmt.sv
module iack_vec_fmt
  import iack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 2,
  parameter int TYPE_W = 3
) (
  input  vfmt_e             fmt,
  input  logic [DATA_W-1:0] base,
  input  logic [CHAN_W-1:0] chan,
  input  logic [TYPE_W-1:0] typ,
  output logic [DATA_W-1:0] vec
);

  localparam int LOW_CT = CHAN_W + TYPE_W;

  generate
    if (LOW_CT >= DATA_W) begin : g_width_bad
      $error("iack_vec_fmt: channel and type fields do not fit in the vector");
    end
  endgenerate

  always_comb begin
    case (fmt)
      VF_FULL:      vec = base;
      VF_CHAN:      vec = {base[DATA_W-1:CHAN_W], chan};
      VF_CHAN_TYPE: vec = {base[DATA_W-1:LOW_CT], chan, typ};
      default:      vec = '0;
    endcase
  end

endmodule

// File: rtl/iack_dack_timer.sv
module iack_dack_timer #(
  parameter int DACK_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic dack
);

  localparam int CNT_W = (DACK_DELAY < 1) ? 1 : $clog2(DACK_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DACK_DELAY);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (active && (cnt_q != CNT_TOP));
    if (start) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign dack = active && (cnt_q == CNT_TOP);

  generate
    if (DACK_DELAY > 0) begin : g_not_early
      AST_DACK_NOT_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> !dack); // R7
    end
  endgenerate

endmodule

// File: rtl/iack_vector_gen.sv
module iack_vector_gen
  import iack_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CHAN_W     = 2,
  parameter int TYPE_W     = 3,
  parameter int DACK_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iack_req,
  input  logic [DATA_W-1:0] ivec_base,
  input  logic [1:0]        ivec_mode,
  input  logic [CHAN_W-1:0] win_chan,
  input  logic [TYPE_W-1:0] win_type,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              dack,
  output logic [CHAN_W-1:0] ctx_chan,
  output logic [TYPE_W-1:0] ctx_type
);

  logic              start;
  logic              active;
  vfmt_e             mode_q;
  logic [DATA_W-1:0] vec;

  iack_cycle_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .iack_req (iack_req),
    .start    (start),
    .active   (active)
  );

  iack_ctx_latch #(.CHAN_W(CHAN_W), .TYPE_W(TYPE_W)) u_ctx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .active  (active),
    .chan_in (win_chan),
    .type_in (win_type),
    .mode_in (vfmt_e'(ivec_mode)),
    .chan_q  (ctx_chan),
    .type_q  (ctx_type),
    .mode_q  (mode_q)
  );

  iack_vec_fmt #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .TYPE_W(TYPE_W)) u_fmt (
    .fmt  (mode_q),
    .base (ivec_base),
    .chan (ctx_chan),
    .typ  (ctx_type),
    .vec  (vec)
  );

  iack_dack_timer #(.DACK_DELAY(DACK_DELAY)) u_dack (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .active (active),
    .dack   (dack)
  );

  always_comb begin
    bus_oe   = active && (mode_q != VF_NONE);
    bus_dout = bus_oe ? vec : '0;
  end

  AST_OE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(iack_req)); // R6
  AST_OE_OFF_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_req |=> !bus_oe); // R6
  AST_NO_VECTOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == VF_NONE) |-> (!bus_oe && bus_dout == '0)); // R5
  AST_DACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> $past(iack_req)); // R7
  AST_DACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && iack_req) |=> dack); // R7
  AST_DACK_OFF_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_req |=> !dack); // R7
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe) && $stable(ivec_base)) |-> $stable(bus_dout)); // R8

endmodule

// File: tb/test_iack_vector_gen.sv
module test_iack_vector_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DELAY      = 2;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic [7:0] data;
    logic       oe;
    logic       dack;
    logic [1:0] chan;
    logic [2:0] typ;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       iack_req;
  logic [7:0] ivec_base;
  logic [1:0] ivec_mode;
  logic [1:0] win_chan;
  logic [2:0] win_type;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic       dack;
  logic [1:0] ctx_chan;
  logic [2:0] ctx_type;

  int   checks   = 0;
  int   failures = 0;
  exp_t sb_q[$];
  logic [1:0] last_chan = 2'b00;
  logic [2:0] last_type = 3'b000;

  always #(CLK_PERIOD/2) clk = ~clk;

  iack_vector_gen #(.DACK_DELAY(DELAY)) i_iack_vector_gen (
    .clk(clk), .rst_n(rst_n), .iack_req(iack_req), .ivec_base(ivec_base),
    .ivec_mode(ivec_mode), .win_chan(win_chan), .win_type(win_type),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .dack(dack),
    .ctx_chan(ctx_chan), .ctx_type(ctx_type)
  );

  // monitor: compare one expected item per clock, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (bus_dout !== e.data || bus_oe !== e.oe || dack !== e.dack ||
            ctx_chan !== e.chan || ctx_type !== e.typ) begin
          failures++;
          $display("FAIL %s: got dout=%h oe=%b dack=%b chan=%0d type=%0d, exp dout=%h oe=%b dack=%b chan=%0d type=%0d",
                   e.tag, bus_dout, bus_oe, dack, ctx_chan, ctx_type,
                   e.data, e.oe, e.dack, e.chan, e.typ);
        end
      end
    end
  end

  function automatic logic [7:0] model_vec(logic [1:0] m, logic [7:0] b,
                                           logic [1:0] c, logic [2:0] t);
    case (m)
      2'b00:   return b;                  // R2
      2'b01:   return {b[7:2], c};        // R3
      2'b10:   return {b[7:5], c, t};     // R4
      default: return 8'h00;              // R5
    endcase
  endfunction

  task automatic push_step(logic [7:0] d, logic oe, logic dk, string tag);
    exp_t e;
    e.data = d; e.oe = oe; e.dack = dk;
    e.chan = last_chan; e.typ = last_type; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  // driver: one acknowledge cycle; optionally disturbs winner and format mid-cycle
  task automatic do_ack(logic [1:0] m, logic [7:0] b, logic [1:0] c,
                        logic [2:0] t, int hold, bit disturb, string tag);
    logic [7:0] v;
    logic       oe;
    ivec_mode = m; ivec_base = b; win_chan = c; win_type = t;
    iack_req  = 1'b1;
    last_chan = c; last_type = t;
    v  = model_vec(m, b, c, t);
    oe = (m != 2'b11);
    for (int i = 0; i < hold; i++) begin
      push_step(oe ? v : 8'h00, oe, (i >= DELAY), tag);
      if (disturb && i == 0) begin
        win_chan  = ~c;         // R8
        win_type  = ~t;
        ivec_mode = m ^ 2'b11;  // R9
      end
    end
    iack_req = 1'b0;
    push_step(8'h00, 1'b0, 1'b0, "R6 R7 release");
    push_step(8'h00, 1'b0, 1'b0, "R6 idle");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; iack_req = 1'b0; ivec_base = 8'h00; ivec_mode = 2'b00;
    win_chan = 2'b00; win_type = 3'b000;
    repeat (3) @(negedge clk);
    // R1: reset state, checked while reset is still applied
    checks++;
    if (bus_oe !== 1'b0 || dack !== 1'b0 || bus_dout !== 8'h00 ||
        ctx_chan !== 2'b00 || ctx_type !== 3'b000) begin
      failures++;
      $display("FAIL R1: got oe=%b dack=%b dout=%h chan=%0d type=%0d, exp all zero",
               bus_oe, dack, bus_dout, ctx_chan, ctx_type);
    end
    rst_n = 1'b1;
    ivec_base = 8'hA5; win_chan = 2'b11; win_type = 3'b111;
    push_step(8'h00, 1'b0, 1'b0, "R1");
    push_step(8'h00, 1'b0, 1'b0, "R1");

    do_ack(2'b00, 8'hA5, 2'b10, 3'b101, 4, 1'b0, "R2 R6 R7");
    do_ack(2'b00, 8'h3C, 2'b01, 3'b010, 5, 1'b0, "R2");
    do_ack(2'b01, 8'hFF, 2'b00, 3'b000, 4, 1'b0, "R3");
    do_ack(2'b01, 8'h50, 2'b11, 3'b110, 6, 1'b0, "R3 R7");
    do_ack(2'b10, 8'hFF, 2'b01, 3'b011, 4, 1'b0, "R4");
    do_ack(2'b10, 8'h00, 2'b10, 3'b111, 4, 1'b0, "R4");
    do_ack(2'b11, 8'hC3, 2'b11, 3'b001, 5, 1'b0, "R5 R7");
    do_ack(2'b10, 8'h9A, 2'b01, 3'b100, 5, 1'b1, "R8 R9");
    do_ack(2'b11, 8'h77, 2'b10, 3'b010, 4, 1'b1, "R9 R5");
    do_ack(2'b01, 8'hE4, 2'b00, 3'b011, 4, 1'b1, "R8 R3");

    wait (sb_q.size() == 0);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule